// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory: Programming-Mode Controller

This block is the device-side logic of a byte-wide, one-time-programmable memory while it sits in its programming mode. Three active-low control inputs, chip enable (`ceN`), output enable (`oeN`) and the program strobe (`pgmN`), are sampled on the block clock. Their combination selects one of several behaviours. The block can read or verify a byte, float the data bus, stand by, collect a four-byte page, burn that page, burn a single byte, or refuse to write at all. The cell array is modelled as registers. Every cell leaves reset blank at 0xFF, and programming can only clear bits.

A programmer fills the page buffer one byte per clock. The address's two low bits pick the slot and the remaining bits give the page base. It then issues a low pulse on the strobe with chip enable and output enable both high. `pageSel` decides whether that pulse commits the buffered page or the single byte on the bus. A commit needs the programming-supply qualifier `progEn`. Several devices can share the address and data lines: a device whose strobe stays high is not written, and a device whose output enable is high releases the bus.

Top module: `otpProgCtrl`

## Requirements
- R1: With `ceN`=0 and `oeN`=0, `dataOe` is 1 and `dataOut` equals the stored byte at `addr` in the same cycle, with no clock latency.
- R2: With `oeN`=1, `dataOe` is 0.
- R3: With `ceN`=1, `dataOe` is 0 whatever the level of `oeN`.
- R4: A clock edge that samples `ceN`=1, `pgmN`=1 and `oeN`=0 stores `dataIn` into page slot `addr[1:0]`. The page base becomes `addr` with bits [1:0] cleared, taken from the most recently latched address.
- R5: A commit fires on the first edge that samples `pgmN`=0 after an edge that sampled it high, with `ceN`=1, `oeN`=1 and `progEn`=1. With `pageSel`=1, that commit writes slot k into the cell at page base + k, for k = 0 to 3.
- R6: The same commit with `pageSel`=0 writes `dataIn` into the cell at `addr` only. No other cell changes.
- R7: While `pgmN` stays high, no cell changes in any mode.
- R8: With `progEn`=0, a strobe pulse leaves every cell unchanged.
- R9: Every write is the bitwise AND of the new data with the old cell, so bits only go from 1 to 0. After reset, every cell reads 0xFF.
- R10: A strobe held low for several cycles commits exactly once. Data changed on the bus later in that pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| pgmN | input | 1 | Program strobe, active low |
| progEn | input | 1 | Programming supply qualified |
| pageSel | input | 1 | 1: a pulse commits the page buffer; 0: it commits one byte |
| addr | input | ADDR_W | Cell address |
| dataIn | input | DATA_W | Data presented for latching or byte writes |
| dataOut | output | DATA_W | Stored byte at `addr` |
| dataOe | output | 1 | Drive enable for `dataOut` (tri-state control) |

## Verification
A wrong page-buffer slot or a stale page base only becomes visible at the ports after a page commit and a readback. A transposed or misplaced byte shows up on the first read of that page. A strobe decode error, such as a second commit during a long pulse or a write with the supply off or the strobe high, leaves cells with too many cleared bits. That also shows only on the next read of the touched cell. The bench therefore reads every cell a stimulus could have touched right after each operation, while bus-enable errors appear in the same cycle as the control change.

// File: rtl/otpProgPkg.sv
package otpProgPkg;
  typedef struct packed {
    logic latchEn;
    logic pageCommit;
    logic byteCommit;
  } opStrobe_t;
endpackage

// File: rtl/otpProgCtrl_ctl.sv
module otpProgCtrl_ctl
  import otpProgPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      pgmN,
  input  logic      progEn,
  input  logic      pageSel,
  output opStrobe_t strb,
  output logic      dataOe
);
  logic pgmPrev;
  logic pgmFall;
  logic burnWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pgmPrev <= 1'b1;
    else       pgmPrev <= pgmN;
  end

  assign pgmFall    = pgmPrev & ~pgmN;
  assign burnWindow = pgmFall & ceN & oeN & progEn;

  always_comb begin
    strb            = '0;
    strb.latchEn    = ceN & pgmN & ~oeN;
    strb.pageCommit = burnWindow & pageSel;
    strb.byteCommit = burnWindow & ~pageSel;
  end

  assign dataOe = ~ceN & ~oeN;

  p_one_op_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchEn, strb.pageCommit, strb.byteCommit}));
  p_no_burn_unpowered_r8: assert property (@(posedge clk) disable iff (!rstN)
    !progEn |-> !(strb.pageCommit || strb.byteCommit));
  p_inhibit_high_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    pgmN |-> !(strb.pageCommit || strb.byteCommit));
  p_single_burn_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pageCommit || strb.byteCommit) |=> !(strb.pageCommit || strb.byteCommit));
endmodule

// File: rtl/otpProgCtrl_dp.sv
module otpProgCtrl_dp
  import otpProgPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int PAGE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  opStrobe_t         strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] readData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PB    = $clog2(PAGE);
  localparam int HI_W  = ADDR_W - PB;

  logic [DATA_W-1:0] mem       [DEPTH];
  logic [DATA_W-1:0] pageLatch [PAGE];
  logic [HI_W-1:0]   baseHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi <= '0;
      for (int p = 0; p < PAGE; p++) pageLatch[p] <= '1;
    end else if (strb.latchEn) begin
      baseHi               <= addr[ADDR_W-1:PB];
      pageLatch[addr[PB-1:0]] <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.pageCommit) begin
      for (int p = 0; p < PAGE; p++)
        mem[{baseHi, PB'(p)}] <= mem[{baseHi, PB'(p)}] & pageLatch[p];
    end else if (strb.byteCommit) begin
      mem[addr] <= mem[addr] & dataIn;
    end
  end

  assign readData = mem[addr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cellChk
    p_bits_only_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
      (mem[g] & ~$past(mem[g])) == '0);
  end
endmodule

// File: rtl/otpProgCtrl.sv
module otpProgCtrl
  import otpProgPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int PAGE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              progEn,
  input  logic              pageSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  opStrobe_t strb;

  otpProgCtrl_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .progEn(progEn), .pageSel(pageSel), .strb(strb), .dataOe(dataOe)
  );

  otpProgCtrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE(PAGE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .readData(dataOut)
  );
endmodule

// File: tb/otpProgCtrl_bench.sv
module otpProgCtrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 0, rstN = 0;
  logic ceN = 1, oeN = 1, pgmN = 1, progEn = 1, pageSel = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe;
  logic [7:0] model [DEPTH];
  int total = 0, bad = 0;
  bit done = 0;

  otpProgCtrl u_otpProgCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .progEn(progEn), .pageSel(pageSel), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk); ceN = 1; oeN = 1; pgmN = 1;
  endtask

  task automatic readCell(input string req, input int a);
    @(negedge clk); ceN = 0; oeN = 0; pgmN = 1; addr = ADDR_W'(a);
    #1;
    check(req, dataOe, 1);
    check(req, dataOut, model[a]);
  endtask

  task automatic latchByte(input int a, input logic [7:0] d);
    @(negedge clk); ceN = 1; oeN = 0; pgmN = 1; addr = ADDR_W'(a); dataIn = d;
  endtask

  task automatic pulse(input int a, input logic [7:0] d, input int lowCycles);
    @(negedge clk); ceN = 1; oeN = 1; pgmN = 0; addr = ADDR_W'(a); dataIn = d;
    for (int i = 1; i < lowCycles; i++) begin
      @(negedge clk); dataIn = 8'h00;
    end
    @(negedge clk); pgmN = 1;
  endtask

  task automatic tReset();
    for (int i = 0; i < DEPTH; i += 9) readCell("R9 blank", i);
    idle(); #1; check("R3 standby", dataOe, 0);
  endtask

  task automatic tBusEnables();
    @(negedge clk); ceN = 0; oeN = 1; #1; check("R2 oe high", dataOe, 0);
    @(negedge clk); ceN = 1; oeN = 0; #1; check("R3 ce high oe low", dataOe, 0);
    @(negedge clk); ceN = 1; oeN = 1; #1; check("R3 ce high oe high", dataOe, 0);
  endtask

  task automatic tPageWrite();
    logic [7:0] d [4] = '{8'hA5, 8'h3C, 8'h0F, 8'hF0};
    pageSel = 1; progEn = 1;
    latchByte(6'h13, d[3]); latchByte(6'h11, d[1]);
    latchByte(6'h10, d[0]); latchByte(6'h12, d[2]);
    pulse(6'h00, 8'h00, 1);
    for (int k = 0; k < 4; k++) model[16+k] &= d[k];
    for (int k = 0; k < 4; k++) readCell("R4 R5 page", 16 + k);
    readCell("R5 neighbour", 15); readCell("R5 neighbour", 20);
  endtask

  task automatic tByteWrite();
    pageSel = 0; progEn = 1;
    pulse(6'h25, 8'h5A, 1);
    model[6'h25] &= 8'h5A;
    readCell("R6 byte", 6'h25); readCell("R6 other", 6'h24);
    pulse(6'h25, 8'hF3, 1);
    model[6'h25] &= 8'hF3;
    readCell("R9 and", 6'h25);
  endtask

  task automatic tInhibit();
    pageSel = 0; progEn = 1;
    @(negedge clk); ceN = 1; oeN = 1; pgmN = 1; addr = 6'h30; dataIn = 8'h00;
    repeat (3) @(negedge clk);
    readCell("R7 inhibit", 6'h30);
    pageSel = 1; latchByte(6'h30, 8'h00);
    @(negedge clk); ceN = 1; oeN = 1; pgmN = 1;
    repeat (2) @(negedge clk);
    readCell("R7 inhibit page", 6'h30);
  endtask

  task automatic tNoSupply();
    pageSel = 0; progEn = 0;
    pulse(6'h31, 8'h00, 1);
    readCell("R8 no supply", 6'h31);
    progEn = 1;
  endtask

  task automatic tLongPulse();
    pageSel = 0; progEn = 1;
    pulse(6'h38, 8'hF0, 3);
    model[6'h38] &= 8'hF0;
    readCell("R10 once", 6'h38);
    readCell("R1 read", 6'h39);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (2) @(negedge clk);
    rstN = 1;
    tReset();
    tBusEnables();
    tPageWrite();
    tByteWrite();
    tInhibit();
    tNoSupply();
    tLongPulse();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule